// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream port and decides when the port must signal a hot-plug interrupt. Software reaches both registers through a single 32-bit register word. Slot control sits in bits 15:0 and slot status in bits 31:16. A four-bit byte enable selects the lanes a write touches, and the read port returns the whole word at all times.

Hardware inputs report a runtime card insertion, a removal request, an attention-button press and a boot-time presence strap. The block evaluates a pending level from the enabled events. It reports a change of that level either as a one-cycle message request or on a legacy level interrupt, depending on which message modes are enabled. When software powers off a populated slot, a detach pulse asks the secondary side to remove its functions. While the electromechanical interlock is engaged, insertion and removal requests are refused with a busy pulse.

Top module: `hp_slot_ctrl`

## Requirements
- R1: Reset values depend on the presence strap `boot_present`. With the strap at 0, the read word is 0x0000_07C0. With the strap at 1, it is 0x0040_01C0. In both cases the attention indicator reads off (bits 7:6 = 11). The power indicator (bits 9:8, 01 = on, 11 = off) and the power controller (bit 10, 1 = off) follow the strap. Status presence (bit 22 of the word) equals the strap, and every other status bit is clear.
- R2: Control bits 0, 3, 4, 5 and 10:6 keep the value last written into an enabled byte lane. Control bit 11 (interlock control) always reads 0.
- R3: Any write with byte enable 0 or 1 set counts as one command, and status bit 4 (command completed) is set after it.
- R4: Each command with control bit 11 written as 1 inverts status bit 7 (interlock status).
- R5: A write to status lanes clears the event bits 0, 3 and 4 where a 1 is written. Presence state (status bit 6) and interlock status (bit 7) are not changed by status writes.
- R6: The pending level is control bit 5 AND any bit set in (status AND control AND 0x0019). With neither message mode enabled, `irq` takes the new pending level one cycle after the level changes, and `irq` drops once the pending level is 0.
- R7: With a message mode enabled, each change of the pending level gives exactly one `msg_req` pulse and `irq` holds its value. `msg_sel` reads 10 when `msix_en` is set, 01 when only `msi_en` is set, and 00 otherwise.
- R8: Raising an event that is already set produces no new notification.
- R9: A command issued while presence state is set, with control bit 10 = 1 and control bits 9:8 = 11, gives a one-cycle `detach` pulse, clears presence state and sets status bit 3. The same command with the slot empty gives no pulse.
- R10: An unlocked `ins_req` sets presence state and status bits 3 and 0. `btn_press` and an unlocked `rem_req` set status bit 0.
- R11: While interlock status is set, `ins_req` or `rem_req` changes no status and gives a one-cycle `busy` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables; lanes 1:0 control, lanes 3:2 status |
| wr_data | input | 32 | Write data word |
| rd_data | output | 32 | Current {status, control} word |
| ins_req | input | 1 | Runtime card insertion (one-cycle pulse) |
| rem_req | input | 1 | Removal request (one-cycle pulse) |
| btn_press | input | 1 | Attention-button press (one-cycle pulse) |
| boot_present | input | 1 | Static strap: slot populated at reset |
| msi_en | input | 1 | Single-vector message mode enabled |
| msix_en | input | 1 | Table-based message mode enabled |
| irq | output | 1 | Legacy level interrupt |
| msg_req | output | 1 | One-cycle message request |
| msg_sel | output | 2 | Selected message mode |
| detach | output | 1 | One-cycle request to remove secondary functions |
| busy | output | 1 | One-cycle refusal of a request while locked |

## Verification
On every cycle, the assertions check the following:
- a command always leaves command-completed set;
- a command carrying an interlock-control 1 flips the interlock status;
- a detach pulse leaves presence state cleared;
- a busy pulse only follows a locked slot;
- message requests appear only in message mode;
- `irq` is frozen while a message mode is enabled.

Only the directed scenarios can show the following:
- the exact register values after reset and after each write;
- that a repeated event gives no second notification;
- that status writes leave presence and interlock untouched;
- the legacy interrupt following the pending level through insertion, clearing and mode switches.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

  // Slot control bit positions
  localparam int C_ABP_EN   = 0;
  localparam int C_PDC_EN   = 3;
  localparam int C_CC_EN    = 4;
  localparam int C_HP_IE    = 5;
  localparam int C_AIND_LO  = 6;
  localparam int C_PIND_LO  = 8;
  localparam int C_PWR_OFF  = 10;
  localparam int C_ILK_CTL  = 11;

  // Slot status bit positions
  localparam int S_ABP      = 0;
  localparam int S_PDC      = 3;
  localparam int S_CC       = 4;
  localparam int S_PDS      = 6;
  localparam int S_ILK      = 7;

  typedef enum logic [1:0] {
    IND_RSVD  = 2'b00,
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_e;

  typedef enum logic [1:0] {
    SIG_LEGACY = 2'b00,
    SIG_MSI    = 2'b01,
    SIG_MSIX   = 2'b10
  } sig_mode_e;

  // Event bits that may raise the pending level
  localparam logic [15:0] EVT_MASK  = 16'h0019;
  // Control bits that keep written values (bit 11 self-clears)
  localparam logic [15:0] CTL_WMASK = 16'h07F9;

endpackage

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
#(
  parameter int REG_W = 16,
  localparam int BUS_W = 2 * REG_W,
  localparam int BE_W  = BUS_W / 8,
  localparam int LANES = BE_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BE_W-1:0]  wr_be,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             ins_req,
  input  logic             rem_req,
  input  logic             btn_press,
  input  logic             boot_present,
  output logic [REG_W-1:0] ctl_q,
  output logic [REG_W-1:0] sts_q,
  output logic             detach_q,
  output logic             busy_q
);

  logic             ctl_touch, sts_touch, upd_en;
  logic [REG_W-1:0] ctl_merge, sts_w1;
  logic [REG_W-1:0] ctl_d, sts_d, rst_ctl, rst_sts;
  logic             detach_d, busy_d;

  // Reset image follows the presence strap
  always_comb begin
    rst_ctl = '0;
    rst_ctl[C_AIND_LO +: 2] = IND_OFF;
    rst_ctl[C_PIND_LO +: 2] = boot_present ? IND_ON : IND_OFF;
    rst_ctl[C_PWR_OFF]      = ~boot_present;
    rst_sts = '0;
    rst_sts[S_PDS]          = boot_present;
  end

  // Next-state logic
  always_comb begin
    ctl_touch = wr_en & (|wr_be[LANES-1:0]);
    sts_touch = wr_en & (|wr_be[BE_W-1:LANES]);
    upd_en    = wr_en | ins_req | rem_req | btn_press;

    ctl_merge = ctl_q;
    sts_w1    = '0;
    for (int b = 0; b < LANES; b++) begin
      if (wr_be[b])
        ctl_merge[b*8 +: 8] = wr_data[b*8 +: 8];
      if (wr_be[LANES + b])
        sts_w1[b*8 +: 8] = wr_data[REG_W + b*8 +: 8];
    end

    ctl_d    = ctl_q;
    sts_d    = sts_q;
    detach_d = 1'b0;
    busy_d   = 1'b0;

    if (sts_touch)
      sts_d = sts_d & ~(sts_w1 & EVT_MASK);

    if (ctl_touch) begin
      ctl_d = ctl_merge & CTL_WMASK;
      if (ctl_merge[C_ILK_CTL])
        sts_d[S_ILK] = ~sts_d[S_ILK];
      if (sts_q[S_PDS] && ctl_merge[C_PWR_OFF] &&
          (ctl_merge[C_PIND_LO +: 2] == IND_OFF)) begin
        detach_d     = 1'b1;
        sts_d[S_PDS] = 1'b0;
        sts_d[S_PDC] = 1'b1;
      end
      sts_d[S_CC] = 1'b1;
    end

    if (ins_req | rem_req) begin
      if (sts_q[S_ILK]) begin
        busy_d = 1'b1;
      end else begin
        if (ins_req) begin
          sts_d[S_PDS] = 1'b1;
          sts_d[S_PDC] = 1'b1;
          sts_d[S_ABP] = 1'b1;
        end
        if (rem_req)
          sts_d[S_ABP] = 1'b1;
      end
    end

    if (btn_press)
      sts_d[S_ABP] = 1'b1;
  end

  // Register state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= rst_ctl;
      sts_q <= rst_sts;
    end else if (upd_en) begin
      ctl_q <= ctl_d;
      sts_q <= sts_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      detach_q <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      detach_q <= detach_d;
      busy_q   <= busy_d;
    end
  end

  // R3
  cmd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_touch |=> sts_q[S_CC]);

  // R4
  ilock_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_touch && ctl_merge[C_ILK_CTL]) |=> (sts_q[S_ILK] != $past(sts_q[S_ILK])));

  // R9
  detach_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (detach_q && !$past(ins_req)) |-> (!sts_q[S_PDS] && sts_q[S_PDC]));

  // R11
  busy_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> $past(sts_q[S_ILK]));

endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ctl_q,
  input  logic [REG_W-1:0] sts_q,
  input  logic             msi_en,
  input  logic             msix_en,
  output logic             irq_q,
  output logic             msg_q,
  output logic [1:0]       msg_sel
);

  logic pend, prev_q, change, msg_on;
  logic irq_d, msg_d;

  always_comb begin
    pend   = ctl_q[C_HP_IE] & (|(sts_q & ctl_q & EVT_MASK));
    change = pend ^ prev_q;
    msg_on = msi_en | msix_en;
    msg_d  = change & msg_on;
    irq_d  = irq_q;
    if (!msg_on) begin
      if (change)
        irq_d = pend;
      else if (!pend)
        irq_d = 1'b0;
    end
    if (msix_en)
      msg_sel = SIG_MSIX;
    else if (msi_en)
      msg_sel = SIG_MSI;
    else
      msg_sel = SIG_LEGACY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
      msg_q  <= 1'b0;
    end else begin
      prev_q <= pend;
      irq_q  <= irq_d;
      msg_q  <= msg_d;
    end
  end

  // R7
  msg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_q |-> $past(msi_en | msix_en));

  // R7
  irq_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_on |=> $stable(irq_q));

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(pend));

endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int REG_W = 16,
  localparam int BUS_W = 2 * REG_W,
  localparam int BE_W  = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BE_W-1:0]  wr_be,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  input  logic             ins_req,
  input  logic             rem_req,
  input  logic             btn_press,
  input  logic             boot_present,
  input  logic             msi_en,
  input  logic             msix_en,
  output logic             irq,
  output logic             msg_req,
  output logic [1:0]       msg_sel,
  output logic             detach,
  output logic             busy
);

  logic [REG_W-1:0] ctl_q, sts_q;

  hp_slot_regs #(.REG_W(REG_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_be        (wr_be),
    .wr_data      (wr_data),
    .ins_req      (ins_req),
    .rem_req      (rem_req),
    .btn_press    (btn_press),
    .boot_present (boot_present),
    .ctl_q        (ctl_q),
    .sts_q        (sts_q),
    .detach_q     (detach),
    .busy_q       (busy)
  );

  hp_slot_notify #(.REG_W(REG_W)) u_notify (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_q   (ctl_q),
    .sts_q   (sts_q),
    .msi_en  (msi_en),
    .msix_en (msix_en),
    .irq_q   (irq),
    .msg_q   (msg_req),
    .msg_sel (msg_sel)
  );

  assign rd_data = {sts_q, ctl_q};

endmodule

// File: tb/hp_slot_ctrl_tb.sv
`timescale 1ns/1ps
module hp_slot_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        ins_req, rem_req, btn_press, boot_present, msi_en, msix_en;
  logic        irq, msg_req, detach, busy;
  logic [1:0]  msg_sel;

  int checks = 0;
  int errors = 0;
  int msg_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hp_slot_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .ins_req(ins_req), .rem_req(rem_req), .btn_press(btn_press),
    .boot_present(boot_present), .msi_en(msi_en), .msix_en(msix_en), .irq(irq),
    .msg_req(msg_req), .msg_sel(msg_sel), .detach(detach), .busy(busy)
  );

  always @(negedge clk) if (rst_n && msg_req) msg_cnt++;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    step();
    wr_en = 1'b0; wr_be = '0; wr_data = '0;
  endtask

  task automatic pulse_ins();
    ins_req = 1'b1; step(); ins_req = 1'b0;
  endtask

  task automatic apply_reset(input logic strap);
    rst_n = 1'b0; boot_present = strap;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_empty();
    apply_reset(1'b0);
    chk("R1 reset word empty", rd_data, 32'h0000_07C0);
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_command();
    wr(4'b0011, 32'h0000_0839);
    chk("R2 R3 R4 first command", rd_data, 32'h0090_0039);
    step();
    chk("R6 irq on completion", {31'd0, irq}, 32'd1);
    wr(4'b0011, 32'h0000_0839);
    chk("R4 interlock back", rd_data, 32'h0010_0039);
    step();
    chk("R8 irq held", {31'd0, irq}, 32'd1);
    chk("R6 no msg in legacy", msg_cnt, 0);
  endtask

  task automatic t_clear();
    wr(4'b0100, 32'h00D9_0000);
    chk("R5 w1c keeps pds ilock", rd_data, 32'h0000_0039);
    step();
    chk("R6 irq drops", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_insert();
    pulse_ins();
    chk("R10 insertion events", rd_data, 32'h0049_0039);
    step();
    chk("R6 irq on insertion", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_msg();
    int base;
    msi_en = 1'b1;
    step(); step();
    base = msg_cnt;
    btn_press = 1'b1; step(); btn_press = 1'b0;
    repeat (3) step();
    chk("R8 repeat event no msg", msg_cnt - base, 0);
    wr(4'b0100, 32'h0019_0000);
    chk("R5 events cleared", rd_data, 32'h0040_0039);
    step(); step();
    chk("R7 one msg on change", msg_cnt - base, 1);
    chk("R7 irq held in msg mode", {31'd0, irq}, 32'd1);
    chk("R7 sel single", {30'd0, msg_sel}, 32'd1);
    msix_en = 1'b1;
    @(negedge clk);
    chk("R7 sel table", {30'd0, msg_sel}, 32'd2);
    msi_en = 1'b0; msix_en = 1'b0;
    step(); step();
    chk("R7 sel legacy", {30'd0, msg_sel}, 32'd0);
    chk("R6 irq low with pend 0", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_detach();
    wr(4'b0011, 32'h0000_0739);
    chk("R9 detach pulse", {31'd0, detach}, 32'd1);
    chk("R9 detach status", rd_data, 32'h0018_0739);
    step();
    chk("R9 detach one cycle", {31'd0, detach}, 32'd0);
    chk("R6 irq on presence change", {31'd0, irq}, 32'd1);
    wr(4'b0011, 32'h0000_0739);
    chk("R9 no detach when empty", {31'd0, detach}, 32'd0);
  endtask

  task automatic t_locked();
    wr(4'b0011, 32'h0000_0F39);
    chk("R4 lock engaged", rd_data, 32'h0098_0739);
    pulse_ins();
    chk("R11 busy on insertion", {31'd0, busy}, 32'd1);
    chk("R11 status unchanged", rd_data, 32'h0098_0739);
    rem_req = 1'b1; step(); rem_req = 1'b0;
    chk("R11 busy on removal", {31'd0, busy}, 32'd1);
    wr(4'b0100, 32'h0080_0000);
    chk("R5 status write keeps lock", rd_data, 32'h0098_0739);
    chk("R11 busy single cycle", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_reset_full();
    apply_reset(1'b1);
    chk("R1 reset word populated", rd_data, 32'h0040_01C0);
    chk("R1 reset detach", {31'd0, detach}, 32'd0);
    step();
    chk("R1 reset irq populated", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_be = '0; wr_data = '0;
    ins_req = 1'b0; rem_req = 1'b0; btn_press = 1'b0;
    boot_present = 1'b0; msi_en = 1'b0; msix_en = 1'b0;
    t_reset_empty();
    t_command();
    t_clear();
    t_insert();
    t_msg();
    t_detach();
    t_locked();
    t_reset_full();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule